// File: doc/BRIEF.md
# Synchronous DRAM Burst Access Sequencer

This block turns one host request into a complete single-bank access on a synchronous DRAM. A request carries a row, a column, a direction flag and four words of write data. The sequencer opens the row, waits a programmable number of idle command cycles, and then issues the column command. It moves a fixed burst of four words. It then closes the row with a precharge and stays busy for a programmable recovery time. Every command and data transfer is aligned to the rising clock edge.

For a read, the device returns the first word two cycles after the column command, because the CAS latency is two. The sequencer registers each returned word and hands it to the host with a one-cycle strobe. For a write, the sequencer drives the first word in the same cycle as the column command and the remaining three words in the following cycles. The host sees a busy flag for the whole transaction. The host must hold its request until the flag drops. A request presented while the flag is high has no effect.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is applied and after it is released with no request, the device is deselected (chip select high), busy and rd_valid are low, and the data bus is not driven (sd_dq_oe low).
- R2: A request is accepted only when req_valid is high while busy is low. In the next cycle the sequencer issues activate, encoded {cs_n, ras_n, cas_n, we_n} = 0011, with the row zero-extended on sd_addr.
- R3: The column command comes RCD_NOPS+1 cycles after activate, and the cycles between carry NOP (0111). Read is encoded 0101 and write 0100, with the column zero-extended on sd_addr. Every other cycle of a transaction carries NOP.
- R4: For a read, the device's first word is expected two cycles after the read command. rd_valid first rises three cycles after the read command cycle, carrying that word.
- R5: rd_valid is high for exactly four consecutive cycles per read. The words arrive in device order.
- R6: For a write, sd_dq_oe is high in exactly four consecutive cycles, starting with the write command cycle. In beat k, sd_dq_out carries req_wdata[k*DATA_W +: DATA_W], so the lowest word goes first.
- R7: Precharge (0010) is issued 4 cycles after a write command and 6 cycles after a read command.
- R8: busy rises in the cycle after acceptance. It falls RECOVER+1 cycles after the precharge cycle.
- R9: A request that is raised and dropped while busy is high starts no activate and does not change the transaction in progress.
- R10: A request held high across the end of a transaction is accepted in the first cycle busy is low. Its activate then lands RECOVER+2 cycles after the previous precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column of the burst |
| req_wdata | input | 4*DATA_W | Four write words, beat 0 in the low bits |
| busy | output | 1 | Transaction in progress |
| rd_valid | output | 1 | Read word valid strobe |
| rd_data | output | DATA_W | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| sd_dq_out | output | DATA_W | Write data to device |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | DATA_W | Read data from device |

## Verification
The hardest case to reach from the ports is a second request that meets the end of a transaction. One variant is dropped while busy is high and must vanish. The other is held and must be picked up on the very first idle cycle. The bench produces both by timing req_valid against the busy flag. It counts activate commands in a cycle-stamped device model to show the dropped request had no effect. For the held request, it measures the gap between precharge and the next activate. The device model also timestamps every command and checks data-bus ownership on each cycle. This lets the read latency and the write beat alignment be checked at their exact cycles.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 9,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int RCD_NOPS = 2,
  parameter int RECOVER  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ROW_W-1:0]    req_row,
  input  logic [COL_W-1:0]    req_col,
  input  logic [4*DATA_W-1:0] req_wdata,
  output logic                busy,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                sd_cs_n,
  output logic                sd_ras_n,
  output logic                sd_cas_n,
  output logic                sd_we_n,
  output logic [ADDR_W-1:0]   sd_addr,
  output logic [DATA_W-1:0]   sd_dq_out,
  output logic                sd_dq_oe,
  input  logic [DATA_W-1:0]   sd_dq_in
);

  localparam int BURST   = 4;
  localparam int CL      = 2;
  localparam int RD_SPAN = CL + BURST - 1;
  localparam int WR_SPAN = BURST - 1;
  localparam int MAX_A   = (RCD_NOPS > RECOVER) ? RCD_NOPS : RECOVER;
  localparam int MAX_CNT = (MAX_A > RD_SPAN) ? MAX_A : RD_SPAN;
  localparam int CNT_W   = $clog2(MAX_CNT + 1) + 1;

  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_ACT   = 4'b0011;
  localparam logic [3:0] C_READ  = 4'b0101;
  localparam logic [3:0] C_WRITE = 4'b0100;
  localparam logic [3:0] C_PRE   = 4'b0010;

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_RCD, S_COL, S_BURST, S_PRE, S_RECOV
  } state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic                wr_q;
  logic [ROW_W-1:0]    row_q;
  logic [COL_W-1:0]    col_q;
  logic [4*DATA_W-1:0] wdata_q;
  logic [3:0]          cmd;
  logic                accept, burst_last, capture;
  logic [1:0]          beat;

  assign accept     = (state == S_IDLE) && req_valid;
  assign burst_last = wr_q ? (cnt == CNT_W'(WR_SPAN)) : (cnt == CNT_W'(RD_SPAN));
  assign capture    = (state == S_BURST) && !wr_q && (cnt >= CNT_W'(CL));
  assign beat       = (state == S_COL) ? 2'd0 : cnt[1:0];
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_ACT;
          wr_q    <= req_write;
          row_q   <= req_row;
          col_q   <= req_col;
          wdata_q <= req_wdata;
        end
        S_ACT: begin
          cnt   <= '0;
          state <= (RCD_NOPS == 0) ? S_COL : S_RCD;
        end
        S_RCD: begin
          if (cnt == CNT_W'(RCD_NOPS - 1)) begin
            cnt   <= '0;
            state <= S_COL;
          end else cnt <= cnt + 1'b1;
        end
        S_COL: begin
          cnt   <= CNT_W'(1);
          state <= S_BURST;
        end
        S_BURST: begin
          if (burst_last) state <= S_PRE;
          else cnt <= cnt + 1'b1;
        end
        S_PRE: begin
          cnt   <= '0;
          state <= (RECOVER == 0) ? S_IDLE : S_RECOV;
        end
        S_RECOV: begin
          if (cnt == CNT_W'(RECOVER - 1)) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= sd_dq_in;
    end
  end

  always_comb begin
    case (state)
      S_IDLE:  cmd = C_DESEL;
      S_ACT:   cmd = C_ACT;
      S_COL:   cmd = wr_q ? C_WRITE : C_READ;
      S_PRE:   cmd = C_PRE;
      default: cmd = C_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_addr   = (state == S_ACT) ? ADDR_W'(row_q) :
                     (state == S_COL) ? ADDR_W'(col_q) : '0;
  assign sd_dq_oe  = wr_q && ((state == S_COL) || (state == S_BURST));
  assign sd_dq_out = sd_dq_oe ? wdata_q[beat*DATA_W +: DATA_W] : '0;

  assert_act_from_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACT) |-> $past(state == S_IDLE && req_valid));

  assert_col_after_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COL) |-> $past(state == S_RCD || state == S_ACT));

  assert_rdvalid_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && !wr_q));

  assert_oe_only_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (wr_q && !sd_cs_n));

  assert_pre_after_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE) |-> $past(state == S_BURST));

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(row_q) && $stable(wr_q) && $stable(col_q)));

endmodule

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;
  localparam int ROW_W = 12, COL_W = 9, ADDR_W = 12, DATA_W = 16;
  localparam int RCD_NOPS = 2, RECOVER = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [4*DATA_W-1:0] req_wdata = '0;
  logic busy, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [DATA_W-1:0] rd_data, sd_dq_out;
  logic [DATA_W-1:0] sd_dq_in = '0;
  logic [ADDR_W-1:0] sd_addr;

  always #2 clk = ~clk;

  sdram_burst_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                    .RCD_NOPS(RCD_NOPS), .RECOVER(RECOVER)) i_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int checks = 0, errors = 0;
  bit done = 0;

  // device model and monitor
  logic [DATA_W-1:0] mem [int];
  int mcyc = 0, act_cyc = 0, col_cyc = 0, pre_cyc = 0, act_cnt = 0, proto_err = 0;
  int act_addr = 0, col_addr = 0, rdv_first = 0, rdv_last = 0, rd_n = 0, busy_fall = 0;
  int oe_first = 0, wbeat_n = 0;
  logic [DATA_W-1:0] rd_beats [4];
  int open_row = -1, rd_t = 0, wr_t = 0, base = 0;
  logic rdv_prev = 0, busy_prev = 0, oe_prev = 0;
  wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always @(posedge clk) begin
    mcyc <= mcyc + 1;
    rdv_prev <= rd_valid; busy_prev <= busy; oe_prev <= sd_dq_oe;
    if (rd_valid) begin
      rd_beats[rd_n % 4] <= rd_data; rd_n <= rd_n + 1;
      if (!rdv_prev) rdv_first <= mcyc;
      rdv_last <= mcyc;
    end
    if (busy_prev && !busy) busy_fall <= mcyc;
    if (sd_dq_oe && !oe_prev) oe_first <= mcyc;
    if (rst_n && sd_dq_oe != ((cmd == 4'b0100) || (wr_t >= 1 && wr_t <= 3))) proto_err <= proto_err + 1;
    if (rd_t >= 1 && rd_t <= 4) begin
      sd_dq_in <= mem.exists(base + rd_t - 1) ? mem[base + rd_t - 1] : 16'hDEAD;
      rd_t <= rd_t + 1;
    end else begin
      sd_dq_in <= '0; rd_t <= 0;
    end
    if (wr_t >= 1 && wr_t <= 3) begin
      mem[base + wr_t] = sd_dq_out; wbeat_n <= wbeat_n + 1;
      wr_t <= (wr_t == 3) ? 0 : wr_t + 1;
    end
    if (rst_n && !sd_cs_n) begin
      case (cmd)
        4'b0011: begin
          if (open_row >= 0) proto_err <= proto_err + 1;
          open_row = int'(sd_addr); act_cyc <= mcyc; act_addr <= int'(sd_addr); act_cnt <= act_cnt + 1;
        end
        4'b0101, 4'b0100: begin
          if (open_row < 0) proto_err <= proto_err + 1;
          col_cyc <= mcyc; col_addr <= int'(sd_addr);
          base = open_row * 1024 + int'(sd_addr);
          if (cmd == 4'b0101) rd_t <= 1;
          else begin mem[base] = sd_dq_out; wbeat_n <= wbeat_n + 1; wr_t <= 1; end
        end
        4'b0010: begin
          if (open_row < 0) proto_err <= proto_err + 1;
          open_row = -1; pre_cyc <= mcyc;
        end
        4'b0111: ;
        default: proto_err <= proto_err + 1;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input int row, input int col, input logic [4*DATA_W-1:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic test_reset;
    check(sd_cs_n == 1, "R1 cs_n", sd_cs_n, 1);
    check(busy == 0, "R1 busy", busy, 0);
    check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    check(sd_dq_oe == 0, "R1 dq_oe", sd_dq_oe, 0);
  endtask

  task automatic test_write(input int row, input int col, input logic [4*DATA_W-1:0] wd);
    int a0 = act_cnt, w0 = wbeat_n;
    issue(1, row, col, wd);
    check(act_cnt == a0 + 1, "R2 one activate", act_cnt - a0, 1);
    check(act_addr == row, "R2 row on address", act_addr, row);
    check(col_cyc - act_cyc == RCD_NOPS + 1, "R3 activate to write", col_cyc - act_cyc, RCD_NOPS + 1);
    check(col_addr == col, "R3 column on address", col_addr, col);
    check(oe_first == col_cyc, "R6 first beat with command", oe_first, col_cyc);
    check(wbeat_n == w0 + 4, "R6 four beats", wbeat_n - w0, 4);
    for (int k = 0; k < 4; k++)
      check(mem[row*1024 + col + k] == wd[k*DATA_W +: DATA_W], "R6 beat data",
            mem[row*1024 + col + k], wd[k*DATA_W +: DATA_W]);
    check(pre_cyc - col_cyc == 4, "R7 precharge after write", pre_cyc - col_cyc, 4);
    check(busy_fall - pre_cyc == RECOVER + 1, "R8 busy fall", busy_fall - pre_cyc, RECOVER + 1);
    check(proto_err == 0, "R3 device protocol", proto_err, 0);
  endtask

  task automatic test_read(input int row, input int col, input logic [4*DATA_W-1:0] exp);
    int n0 = rd_n;
    issue(0, row, col, '0);
    check(act_addr == row, "R2 row on address", act_addr, row);
    check(col_cyc - act_cyc == RCD_NOPS + 1, "R3 activate to read", col_cyc - act_cyc, RCD_NOPS + 1);
    check(rdv_first - col_cyc == 3, "R4 read latency", rdv_first - col_cyc, 3);
    check(rd_n == n0 + 4, "R5 four strobes", rd_n - n0, 4);
    check(rdv_last - rdv_first == 3, "R5 consecutive", rdv_last - rdv_first, 3);
    for (int k = 0; k < 4; k++)
      check(rd_beats[(n0 + k) % 4] == exp[k*DATA_W +: DATA_W], "R4 R5 read word",
            rd_beats[(n0 + k) % 4], exp[k*DATA_W +: DATA_W]);
    check(pre_cyc - col_cyc == 6, "R7 precharge after read", pre_cyc - col_cyc, 6);
    check(busy_fall - pre_cyc == RECOVER + 1, "R8 busy fall", busy_fall - pre_cyc, RECOVER + 1);
    check(proto_err == 0, "R3 device protocol", proto_err, 0);
  endtask

  task automatic test_ignore_busy(input int row, input int col, input logic [4*DATA_W-1:0] exp);
    int a0 = act_cnt, n0 = rd_n;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_row = ROW_W'(row); req_col = COL_W'(col);
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    req_valid = 1; req_write = 1; req_row = ROW_W'(row + 7); req_col = COL_W'(5);
    req_wdata = {4{16'hBAD0}};
    repeat (4) @(negedge clk);
    check(busy == 1, "R9 still busy", busy, 1);
    req_valid = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(act_cnt == a0 + 1, "R9 no extra activate", act_cnt - a0, 1);
    check(act_addr == row, "R9 row kept", act_addr, row);
    for (int k = 0; k < 4; k++)
      check(rd_beats[(n0 + k) % 4] == exp[k*DATA_W +: DATA_W], "R9 data kept",
            rd_beats[(n0 + k) % 4], exp[k*DATA_W +: DATA_W]);
  endtask

  task automatic test_held(input int row, input int col);
    int first_pre, a0 = act_cnt;
    logic [4*DATA_W-1:0] wd = 64'h1111_2222_3333_4444;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = wd;
    @(negedge clk);
    while (busy) @(negedge clk);
    first_pre = pre_cyc;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    check(act_cnt == a0 + 2, "R10 second accepted", act_cnt - a0, 2);
    check(act_cyc - first_pre == RECOVER + 2, "R10 activate gap", act_cyc - first_pre, RECOVER + 2);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(proto_err == 0, "R3 device protocol", proto_err, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    test_reset();
    test_write(12'h0A5, 9'h010, 64'h4444_3333_2222_1111);
    test_write(12'hFFF, 9'h1F8, 64'hDEAD_BEEF_0F0F_F0F0);
    test_read(12'h0A5, 9'h010, 64'h4444_3333_2222_1111);
    test_read(12'hFFF, 9'h1F8, 64'hDEAD_BEEF_0F0F_F0F0);
    test_ignore_busy(12'h0A5, 9'h010, 64'h4444_3333_2222_1111);
    test_held(12'h123, 9'h040);
    test_read(12'h123, 9'h040, 64'h1111_2222_3333_4444);
    finish_run();
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end
endmodule